// File: doc/BRIEF.md
# Floating-point flag check branch unit

This unit resolves a conditional branch that depends on the sticky floating-point exception flags. A qualifying predicate gates the whole operation. A selector chooses one of four status fields, and the unit then tests that field's exception flags against a trap-disable vector and against the flags of status field 0. If any chosen flag is set and either its trap is enabled or field 0 does not yet record it, the branch condition holds. The branch target is the current bundle address plus a signed displacement counted in 16-byte bundles.

A configuration input says whether branching is implemented. When it is not, a true condition raises a speculative-operation fault instead of a branch, and the displacement is delivered zero-extended as an interruption immediate value so that a handler can emulate the branch. A taken branch can also raise a taken-branch trap. When the core cannot fault on unimplemented addresses, a taken branch to an unimplemented address raises an unimplemented-address trap; the address is tested against a virtual or a physical mask, depending on the translation-enable input.

Every strobed request produces a one-cycle result pulse on the clock edge after the strobe. All result outputs are zero in any cycle without that pulse.

Top module: `flagchk_branch`

## Requirements
- R1: When `qual_pred` is 0 on a strobed request, the result has `out_valid`=1 and `br_taken`, `spec_fault`, `taken_trap`, `uaddr_trap` all 0, with `br_target` and `iim_val` 0.
- R2: `field_sel` value i picks the flag set held in `field_flags[6*i+5 : 6*i]` as the set under test; field 0 is always `field_flags[5:0]`.
- R3: The condition holds when some bit is 1 in the chosen flag set and 0 in `trap_disable`, at the same bit position.
- R4: The condition also holds when some bit is 1 in the chosen flag set and 0 in field 0's flag set, at the same bit position.
- R5: When the condition is false, the result carries no branch, fault or trap, and `br_target` and `iim_val` are 0.
- R6: On a taken branch, `br_target` equals `cur_addr` plus the 21-bit `disp` sign-extended and multiplied by 16 (modulo 2^64), so its low 4 bits equal those of `cur_addr`.
- R7: When the condition holds and `branch_impl` is 0, `spec_fault` is 1, `br_taken` is 0, no trap is raised, and `iim_val` is `disp` zero-extended to 64 bits.
- R8: `taken_trap` is 1 exactly when the branch is taken and `taken_trap_en` is 1.
- R9: `uaddr_trap` is 1 exactly when the branch is taken, `uaddr_fault_ok` is 0 and the target is unimplemented; an address is unimplemented if it ANDed with `VA_IMPL_MASK` (when `xlate_en` is 1) or with `PA_IMPL_MASK` (when `xlate_en` is 0) is nonzero.
- R10: `out_valid` is 1 in exactly the cycle after each cycle where `req_valid` is 1; synchronous active-high `rst` clears every output; without `out_valid` every output is 0.
- R11: `br_taken` and `spec_fault` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| qual_pred | input | 1 | Qualifying predicate |
| field_sel | input | 2 | Status field selector |
| field_flags | input | 24 | Four 6-bit flag sets, field i at bits 6i+5..6i |
| trap_disable | input | 6 | Per-flag trap disable bits |
| cur_addr | input | 64 | Address of the current bundle |
| disp | input | 21 | Signed displacement in bundles |
| branch_impl | input | 1 | 1 if the branch behaviour is implemented |
| taken_trap_en | input | 1 | Taken-branch trap enable |
| xlate_en | input | 1 | Translation enable: selects the virtual address mask |
| uaddr_fault_ok | input | 1 | Core handles unimplemented addresses by a fault elsewhere |
| out_valid | output | 1 | Result pulse |
| br_taken | output | 1 | Branch taken |
| br_target | output | 64 | Branch target address |
| taken_trap | output | 1 | Taken-branch trap |
| spec_fault | output | 1 | Speculative-operation fault |
| iim_val | output | 64 | Interruption immediate value |
| uaddr_trap | output | 1 | Unimplemented-instruction-address trap |

## Verification
The bench keeps the default widths but narrows the implemented-address masks: virtual addresses must fit in 24 bits and physical ones in 20 bits. With these masks a displacement of a single bundle from an address just below either limit crosses it, so both trap outcomes and the virtual/physical distinction can be reached with small, readable operands. Between those limits a target lands above the physical limit and below the virtual one, which shows that the mask choice follows `xlate_en`.

// File: rtl/flagchk_pkg.sv
package flagchk_pkg;

  // Bit positions of the exception flags within a 6-bit flag set
  typedef enum int {
    FLG_INVALID  = 0,
    FLG_DENORM   = 1,
    FLG_DIVZERO  = 2,
    FLG_OVERFLOW = 3,
    FLG_UNDERFL  = 4,
    FLG_INEXACT  = 5
  } flag_pos_e;

  // Outcome of one evaluated request
  typedef struct packed {
    logic taken;
    logic fault;
    logic tb_trap;
    logic uia_trap;
  } evt_t;

endpackage

// File: rtl/flagchk_cond.sv
module flagchk_cond #(
  parameter int FLAG_W     = 6,
  parameter int NUM_FIELDS = 4,
  localparam int SEL_W     = (NUM_FIELDS > 1) ? $clog2(NUM_FIELDS) : 1
) (
  input  logic [SEL_W-1:0]             field_sel,
  input  logic [NUM_FIELDS*FLAG_W-1:0] field_flags,
  input  logic [FLAG_W-1:0]            trap_disable,
  output logic [FLAG_W-1:0]            sel_flags,
  output logic                         trap_hit,
  output logic                         new_hit,
  output logic                         cond_hit
);

  logic [FLAG_W-1:0] fset [NUM_FIELDS];

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_unpack
    assign fset[g] = field_flags[g*FLAG_W +: FLAG_W];
  end

  // Any chosen flag whose trap is not disabled
  function automatic logic enabled_any(input logic [FLAG_W-1:0] f,
                                       input logic [FLAG_W-1:0] dis);
    return |(f & ~dis);
  endfunction

  // Any chosen flag not yet recorded in the base field
  function automatic logic unseen_any(input logic [FLAG_W-1:0] f,
                                      input logic [FLAG_W-1:0] base);
    return |(f & ~base);
  endfunction

  always_comb begin
    sel_flags = '0;
    for (int i = 0; i < NUM_FIELDS; i++) begin
      if (SEL_W'(i) == field_sel) sel_flags = fset[i];
    end
  end

  assign trap_hit = enabled_any(sel_flags, trap_disable);
  assign new_hit  = unseen_any(sel_flags, fset[0]);
  assign cond_hit = trap_hit | new_hit;

endmodule

// File: rtl/flagchk_target.sv
module flagchk_target #(
  parameter int              ADDR_W   = 64,
  parameter int              DISP_W   = 21,
  parameter int              ALIGN_SH = 4,
  parameter logic [ADDR_W-1:0] VA_MASK = {3'b000, {(ADDR_W-3-48){1'b1}}, 48'h0},
  parameter logic [ADDR_W-1:0] PA_MASK = {1'b0, {(ADDR_W-1-50){1'b1}}, 50'h0},
  localparam int             OFF_W    = DISP_W + ALIGN_SH
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [DISP_W-1:0] disp,
  input  logic              xlate_en,
  output logic [ADDR_W-1:0] target,
  output logic              va_bad,
  output logic              pa_bad,
  output logic              unimpl
);

  // Displacement in bytes, sign-extended from OFF_W bits to the address width
  function automatic logic [ADDR_W-1:0] bundle_offset(input logic [DISP_W-1:0] d);
    logic [OFF_W-1:0] raw;
    raw = {d, {ALIGN_SH{1'b0}}};
    return {{(ADDR_W-OFF_W){raw[OFF_W-1]}}, raw};
  endfunction

  function automatic logic outside(input logic [ADDR_W-1:0] a,
                                   input logic [ADDR_W-1:0] m);
    return |(a & m);
  endfunction

  assign target = cur_addr + bundle_offset(disp);
  assign va_bad = outside(target, VA_MASK);
  assign pa_bad = outside(target, PA_MASK);
  assign unimpl = xlate_en ? va_bad : pa_bad;

endmodule

// File: rtl/flagchk_resolve.sv
module flagchk_resolve
  import flagchk_pkg::*;
(
  input  logic qual_pred,
  input  logic cond_hit,
  input  logic branch_impl,
  input  logic taken_trap_en,
  input  logic uaddr_fault_ok,
  input  logic tgt_unimpl,
  output evt_t evt
);

  always_comb begin
    evt = '0;
    if (qual_pred && cond_hit) begin
      if (branch_impl) begin
        evt.taken    = 1'b1;
        evt.tb_trap  = taken_trap_en;
        evt.uia_trap = !uaddr_fault_ok && tgt_unimpl;
      end else begin
        evt.fault    = 1'b1;
      end
    end
  end

endmodule

// File: rtl/flagchk_branch.sv
module flagchk_branch
  import flagchk_pkg::*;
#(
  parameter int                ADDR_W     = 64,
  parameter int                DISP_W     = 21,
  parameter int                ALIGN_SH   = 4,
  parameter int                FLAG_W     = 6,
  parameter int                NUM_FIELDS = 4,
  parameter int                IIM_W      = 64,
  parameter logic [ADDR_W-1:0] VA_IMPL_MASK = {3'b000, {(ADDR_W-3-48){1'b1}}, 48'h0},
  parameter logic [ADDR_W-1:0] PA_IMPL_MASK = {1'b0, {(ADDR_W-1-50){1'b1}}, 50'h0},
  localparam int               SEL_W      = (NUM_FIELDS > 1) ? $clog2(NUM_FIELDS) : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         req_valid,
  input  logic                         qual_pred,
  input  logic [SEL_W-1:0]             field_sel,
  input  logic [NUM_FIELDS*FLAG_W-1:0] field_flags,
  input  logic [FLAG_W-1:0]            trap_disable,
  input  logic [ADDR_W-1:0]            cur_addr,
  input  logic [DISP_W-1:0]            disp,
  input  logic                         branch_impl,
  input  logic                         taken_trap_en,
  input  logic                         xlate_en,
  input  logic                         uaddr_fault_ok,
  output logic                         out_valid,
  output logic                         br_taken,
  output logic [ADDR_W-1:0]            br_target,
  output logic                         taken_trap,
  output logic                         spec_fault,
  output logic [IIM_W-1:0]             iim_val,
  output logic                         uaddr_trap
);

  // Named internal events, visible to the bound checker
  logic [FLAG_W-1:0] sel_flags;
  logic              trap_hit;
  logic              new_hit;
  logic              cond_hit;
  logic [ADDR_W-1:0] next_target;
  logic              va_bad;
  logic              pa_bad;
  logic              tgt_unimpl;
  evt_t              evt;

  function automatic logic [IIM_W-1:0] iim_of(input logic [DISP_W-1:0] d);
    return {{(IIM_W-DISP_W){1'b0}}, d};
  endfunction

  flagchk_cond #(
    .FLAG_W    (FLAG_W),
    .NUM_FIELDS(NUM_FIELDS)
  ) u_cond (
    .field_sel   (field_sel),
    .field_flags (field_flags),
    .trap_disable(trap_disable),
    .sel_flags   (sel_flags),
    .trap_hit    (trap_hit),
    .new_hit     (new_hit),
    .cond_hit    (cond_hit)
  );

  flagchk_target #(
    .ADDR_W  (ADDR_W),
    .DISP_W  (DISP_W),
    .ALIGN_SH(ALIGN_SH),
    .VA_MASK (VA_IMPL_MASK),
    .PA_MASK (PA_IMPL_MASK)
  ) u_target (
    .cur_addr(cur_addr),
    .disp    (disp),
    .xlate_en(xlate_en),
    .target  (next_target),
    .va_bad  (va_bad),
    .pa_bad  (pa_bad),
    .unimpl  (tgt_unimpl)
  );

  flagchk_resolve u_resolve (
    .qual_pred     (qual_pred),
    .cond_hit      (cond_hit),
    .branch_impl   (branch_impl),
    .taken_trap_en (taken_trap_en),
    .uaddr_fault_ok(uaddr_fault_ok),
    .tgt_unimpl    (tgt_unimpl),
    .evt           (evt)
  );

  // Single result stage; every output is zero outside the valid pulse
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      br_taken   <= 1'b0;
      br_target  <= '0;
      taken_trap <= 1'b0;
      spec_fault <= 1'b0;
      iim_val    <= '0;
      uaddr_trap <= 1'b0;
    end else begin
      out_valid  <= req_valid;
      br_taken   <= req_valid && evt.taken;
      br_target  <= (req_valid && evt.taken) ? next_target : '0;
      taken_trap <= req_valid && evt.tb_trap;
      spec_fault <= req_valid && evt.fault;
      iim_val    <= (req_valid && evt.fault) ? iim_of(disp) : '0;
      uaddr_trap <= req_valid && evt.uia_trap;
    end
  end

endmodule

// File: rtl/flagchk_checker.sv
module flagchk_checker #(
  parameter int ADDR_W = 64,
  parameter int DISP_W = 21,
  parameter int IIM_W  = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              qual_pred,
  input logic              branch_impl,
  input logic              taken_trap_en,
  input logic [ADDR_W-1:0] cur_addr,
  input logic [DISP_W-1:0] disp,
  input logic              cond_hit,
  input logic              out_valid,
  input logic              br_taken,
  input logic [ADDR_W-1:0] br_target,
  input logic              taken_trap,
  input logic              spec_fault,
  input logic [IIM_W-1:0]  iim_val,
  input logic              uaddr_trap
);

  assert_pulse_follows_req_R10: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_valid);

  assert_no_spurious_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !out_valid);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!br_taken && !spec_fault && !taken_trap && !uaddr_trap
                    && br_target == '0 && iim_val == '0));

  assert_pred_gates_R1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !qual_pred) |=> (!br_taken && !spec_fault && !taken_trap && !uaddr_trap));

  assert_false_cond_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !cond_hit) |=> (!br_taken && !spec_fault && !taken_trap && !uaddr_trap));

  assert_taken_aligned_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && br_taken == 1'b0) ##1 br_taken |-> br_target[3:0] == $past(cur_addr[3:0]));

  assert_fault_immediate_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && qual_pred && cond_hit && !branch_impl)
      |=> (spec_fault && iim_val == {{(IIM_W-DISP_W){1'b0}}, $past(disp)}));

  assert_trap_needs_taken_R8: assert property (@(posedge clk) disable iff (rst)
    taken_trap |-> br_taken);

  assert_trap_enable_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !taken_trap_en) |=> !taken_trap);

  assert_uaddr_needs_taken_R9: assert property (@(posedge clk) disable iff (rst)
    uaddr_trap |-> br_taken);

  assert_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
    !(br_taken && spec_fault));

endmodule

bind flagchk_branch flagchk_checker #(
  .ADDR_W(ADDR_W),
  .DISP_W(DISP_W),
  .IIM_W (IIM_W)
) u_checker (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .qual_pred    (qual_pred),
  .branch_impl  (branch_impl),
  .taken_trap_en(taken_trap_en),
  .cur_addr     (cur_addr),
  .disp         (disp),
  .cond_hit     (cond_hit),
  .out_valid    (out_valid),
  .br_taken     (br_taken),
  .br_target    (br_target),
  .taken_trap   (taken_trap),
  .spec_fault   (spec_fault),
  .iim_val      (iim_val),
  .uaddr_trap   (uaddr_trap)
);

// File: tb/tb_flagchk_branch.sv
`timescale 1ns/1ps
module tb_flagchk_branch;

  localparam logic [63:0] VMASK = 64'hFFFF_FFFF_FF00_0000;
  localparam logic [63:0] PMASK = 64'hFFFF_FFFF_FFF0_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        qual_pred = 1'b0;
  logic [1:0]  field_sel = '0;
  logic [23:0] field_flags = '0;
  logic [5:0]  trap_disable = '0;
  logic [63:0] cur_addr = '0;
  logic [20:0] disp = '0;
  logic        branch_impl = 1'b1;
  logic        taken_trap_en = 1'b0;
  logic        xlate_en = 1'b0;
  logic        uaddr_fault_ok = 1'b0;
  logic        out_valid, br_taken, taken_trap, spec_fault, uaddr_trap;
  logic [63:0] br_target, iim_val;

  always #2.5 clk = ~clk;

  flagchk_branch #(
    .VA_IMPL_MASK(VMASK),
    .PA_IMPL_MASK(PMASK)
  ) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .qual_pred(qual_pred),
    .field_sel(field_sel), .field_flags(field_flags), .trap_disable(trap_disable),
    .cur_addr(cur_addr), .disp(disp), .branch_impl(branch_impl),
    .taken_trap_en(taken_trap_en), .xlate_en(xlate_en), .uaddr_fault_ok(uaddr_fault_ok),
    .out_valid(out_valid), .br_taken(br_taken), .br_target(br_target),
    .taken_trap(taken_trap), .spec_fault(spec_fault), .iim_val(iim_val),
    .uaddr_trap(uaddr_trap)
  );

  typedef struct packed {
    logic        taken;
    logic        fault;
    logic        tbt;
    logic        uia;
    logic [63:0] tgt;
    logic [63:0] iim;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_checks = 0;
  int    n_errors = 0;
  bit    monitor_on = 1'b0;
  bit    finished = 1'b0;

  function automatic exp_t model(input bit qp, input logic [1:0] sel, input logic [23:0] ff,
                                 input logic [5:0] dis, input logic [63:0] cur,
                                 input logic [20:0] d, input bit impl, input bit tbe,
                                 input bit xl, input bit sup);
    exp_t e;
    logic [5:0]  chosen, base;
    bit          hit;
    logic [63:0] ext, tgt;
    e = '0;
    chosen = ff >> (6 * sel);
    base = ff[5:0];
    hit = 1'b0;
    for (int b = 0; b < 6; b++) begin
      if (chosen[b] && (!dis[b] || !base[b])) hit = 1'b1;
    end
    ext = {{43{d[20]}}, d};
    tgt = cur + (ext << 4);
    if (qp && hit) begin
      if (impl) begin
        e.taken = 1'b1;
        e.tgt   = tgt;
        e.tbt   = tbe;
        e.uia   = !sup && (xl ? (tgt[63:24] != 0) : (tgt[63:20] != 0));
      end else begin
        e.fault = 1'b1;
        e.iim   = {43'd0, d};
      end
    end
    return e;
  endfunction

  task automatic check(input string tag, input bit ok, input exp_t act, input exp_t exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input string tag, input bit qp, input logic [1:0] sel,
                      input logic [23:0] ff, input logic [5:0] dis, input logic [63:0] cur,
                      input logic [20:0] d, input bit impl, input bit tbe,
                      input bit xl, input bit sup);
    @(negedge clk);
    req_valid = 1'b1;  qual_pred = qp;   field_sel = sel;  field_flags = ff;
    trap_disable = dis; cur_addr = cur;  disp = d;         branch_impl = impl;
    taken_trap_en = tbe; xlate_en = xl;  uaddr_fault_ok = sup;
    exp_q.push_back(model(qp, sel, ff, dis, cur, d, impl, tbe, xl, sup));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  // Monitor: sample 1 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (monitor_on) begin
        exp_t act;
        act = '{br_taken, spec_fault, taken_trap, uaddr_trap, br_target, iim_val};
        if (out_valid) begin
          if (exp_q.size() == 0) begin
            check("R10 unexpected pulse", 1'b0, act, '0);
          end else begin
            exp_t e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, act == e, act, e);
          end
        end else begin
          check("R10 idle outputs", act == '0, act, '0);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    exp_t z;
    z = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    check("R10 reset state", out_valid == 1'b0 &&
          '{br_taken, spec_fault, taken_trap, uaddr_trap, br_target, iim_val} == z,
          '{br_taken, spec_fault, taken_trap, uaddr_trap, br_target, iim_val}, z);
    monitor_on = 1'b1;

    // R1: predicate false with a condition that would hold
    send("R1 predicate off", 0, 2'd1, 24'h00_0FC0, 6'h00, 64'h1000, 21'd5, 1, 1, 0, 0);
    idle(1);
    // R3: field 0, invalid flag with trap enabled -> taken, forward target
    send("R3 enabled trap R6", 1, 2'd0, 24'h00_0001, 6'h3E, 64'h2000, 21'd3, 1, 0, 0, 0);
    idle(1);
    // R5: field 0 with every trap disabled -> no branch
    send("R5 all disabled", 1, 2'd0, 24'h00_003F, 6'h3F, 64'h2000, 21'd3, 1, 1, 0, 0);
    idle(1);
    // R4: field 2 subset of field 0, traps disabled -> false; then a new flag -> true
    send("R4 subset false", 1, 2'd2, {6'h00, 6'h06, 6'h00, 6'h0F}, 6'h3F, 64'h3000, 21'd1, 1, 0, 0, 0);
    send("R4 unseen flag", 1, 2'd2, {6'h00, 6'h30, 6'h00, 6'h0F}, 6'h3F, 64'h3000, 21'd1, 1, 0, 0, 0);
    idle(1);
    // R2: each selector with only that field carrying an unseen flag
    for (int s = 0; s < 4; s++) begin
      logic [23:0] ff;
      ff = 24'h0;
      ff[6*s +: 6] = 6'h20;
      send("R2 selector", 1, 2'(s), ff, 6'h3F, 64'h4000, 21'd2, 1, 0, 0, 0);
      send("R2 other field", 1, 2'((s + 1) % 4), ff, 6'h3F, 64'h4000, 21'd2, 1, 0, 0, 0);
    end
    idle(1);
    // R6: backward target and low-bit preservation
    send("R6 backward", 1, 2'd1, 24'h00_0200, 6'h3F, 64'h0000_0000_0001_0005, 21'h1FFFF0, 1, 0, 0, 0);
    send("R6 wrap", 1, 2'd0, 24'h000004, 6'h00, 64'h8, 21'h1FFFFF, 1, 0, 0, 1);
    idle(1);
    // R7: branch not implemented, negative displacement is zero-extended
    send("R7 fault R11", 1, 2'd3, 24'h04_0000, 6'h3F, 64'h5000, 21'h1FFFFF, 0, 1, 1, 0);
    send("R7 fault positive", 1, 2'd0, 24'h00_0008, 6'h00, 64'h5000, 21'h0ABCDE, 0, 0, 0, 0);
    idle(1);
    // R8: taken-branch trap enable
    send("R8 trap on", 1, 2'd0, 24'h00_0010, 6'h00, 64'h6000, 21'd1, 1, 1, 0, 0);
    send("R8 trap off", 1, 2'd0, 24'h00_0010, 6'h00, 64'h6000, 21'd1, 1, 0, 0, 0);
    idle(1);
    // R9: boundary crossings under both masks
    send("R9 virtual cross", 1, 2'd0, 24'h1, 6'h0, 64'h00FF_FFF0, 21'd1, 1, 0, 1, 0);
    send("R9 virtual inside", 1, 2'd0, 24'h1, 6'h0, 64'h00FF_FFE0, 21'd1, 1, 0, 1, 0);
    send("R9 physical cross", 1, 2'd0, 24'h1, 6'h0, 64'h000F_FFF0, 21'd1, 1, 0, 0, 0);
    send("R9 mode picks mask", 1, 2'd0, 24'h1, 6'h0, 64'h000F_FFF0, 21'd1, 1, 0, 1, 0);
    send("R9 fault supported", 1, 2'd0, 24'h1, 6'h0, 64'h00FF_FFF0, 21'd1, 1, 0, 1, 1);
    idle(3);
    // R10: gaps between pulses with mixed stimulus
    for (int i = 0; i < 200; i++) begin
      send("R10 mixed R3 R4", 1'($urandom_range(0, 7) != 0), 2'($urandom_range(0, 3)),
           24'($urandom), 6'($urandom), {40'h0, 24'($urandom)} & 64'h00FF_FFF0,
           21'($urandom), 1'($urandom_range(0, 3) != 0), 1'($urandom),
           1'($urandom), 1'($urandom));
      if (i % 3 == 0) idle(1);
    end
    idle(4);
    begin
      exp_t e0;
      e0 = '0;
      e0.tgt = 64'(exp_q.size());
      check("R10 drained", exp_q.size() == 0, e0, '0);
    end
    summary();
  end

endmodule